// File: doc/BRIEF.md
# Cell overcharge delay controller

This block holds the digital timing and control for a secondary overcharge monitor on a pack of two or three series cells. Outside comparators give it, per cell, a flag that is high while the cell is above its overcharge threshold and a release flag that is high while the cell is below threshold minus hysteresis. A slow oscillator supplies a one-cycle tick enable, and all delays are counted in those ticks.

A cell must stay over its threshold for a full detection delay before the block enters overcharge and asserts the charge-control output. Every cell must then stay below its release point for a much shorter release delay before the output goes back to inactive. Holding the test request (supply well above the top cell) long enough latches a test mode that cuts the detection delay. The latch clears when overcharge is reached. Output polarity and output form (push-pull or open-drain) are chosen when the block is built.

Top module: `cell_ovc_guard`

## Requirements
- R1: While `rst_n` is low at a clock edge the block goes to normal status with test mode cleared and both qualification counts at zero, so the output is inactive after reset.
- R2: Normal status becomes overcharge at the tick on which any cell's `ovc_flag` has been seen high on `DET_BASE_TICKS << DELAY_CODE` consecutive ticks (DELAY_CODE 0, 1, 2 selects the 1x, 2x, 4x delay).
- R3: If the detection condition is low at any clock edge, the detection count restarts from zero, so shorter bursts never cause overcharge.
- R4: Overcharge returns to normal only after every cell's `rel_flag` has been high together on `REL_TICKS` consecutive ticks. A drop of any one of them restarts the count.
- R5: Holding `test_req` high for `TEST_ENTRY_TICKS` consecutive ticks latches test mode, which stays set after `test_req` falls. A shorter hold latches nothing.
- R6: While test mode is latched, the detection delay is `TEST_DET_TICKS` ticks instead of the normal delay.
- R7: Reaching overcharge clears test mode, so the next detection takes the normal delay again.
- R8: With `ACTIVE_HIGH`=1 the driven output level is 1 in overcharge and 0 in normal status. With `ACTIVE_HIGH`=0 the levels are swapped.
- R9: With `OPEN_DRAIN`=0, `chg_oe` is always 1. With `OPEN_DRAIN`=1, `chg_oe` is 1 only in overcharge (inactive means high impedance).
- R10: With `two_cell`=1, the flags of the top cell index (NUM_CELLS-1) are ignored: its overcharge flag counts as low and its release flag as high.
- R11: The counts advance only on clock edges where `tick` is 1. Edges without a tick neither advance nor restart a held condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Oscillator tick enable, one clock wide |
| two_cell | input | 1 | 1: pack has one cell fewer, top cell's flags ignored |
| ovc_flag | input | NUM_CELLS | Per cell: above overcharge threshold (synchronized) |
| rel_flag | input | NUM_CELLS | Per cell: below threshold minus hysteresis (synchronized) |
| test_req | input | 1 | Test entry condition present (synchronized) |
| chg_out | output | 1 | Charge-control level when driven |
| chg_oe | output | 1 | Output enable; 0 means high impedance |

## Verification
Status changes are registered. With `tick` high on every clock, overcharge shows on the outputs just after the N-th rising edge at which the detection condition was sampled high, where N is the active delay. Release shows just after the `REL_TICKS`-th edge, and test mode is latched after the `TEST_ENTRY_TICKS`-th edge. The bench drives inputs at falling edges and checks at falling edges, one edge before and exactly on the edge where each change is due. It sweeps burst lengths up to one short of the delay, every cell, and each missing release flag, and it runs a push-pull active-high build and an open-drain active-low build side by side.

// File: rtl/cog_pkg.sv
// Shared types for the cell overcharge guard.
// Assumes: nothing beyond the standard language.
package cog_pkg;
    typedef enum logic {
        ST_NORMAL = 1'b0,
        ST_OVC    = 1'b1
    } guard_state_t;

    // Larger of two integers, for deriving counter widths.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/cog_qual_timer.sv
// Qualification timer: counts ticks while a condition holds and fires on the
// tick that completes `limit` consecutive qualifying ticks.
// Assumes: limit >= 1; limit may change while counting (fires at once if the
// count is already at or past the new limit); caller drops cond after fire.
module cog_qual_timer #(
    parameter int MAX_COUNT = 16,
    localparam int CW = $clog2(MAX_COUNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cond,
    input  logic [CW-1:0] limit,
    output logic          fire
);
    logic [CW-1:0] cnt;
    logic          reached;

    // Count reaches the limit on this tick.
    always_comb begin
        reached = ({1'b0, cnt} + {{CW{1'b0}}, 1'b1}) >= {1'b0, limit};
        fire    = cond && tick && reached;
    end

    // Restart on any drop of the condition, advance on tick, saturate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!cond) begin
            cnt <= '0;
        end else if (tick && !reached) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> (cnt == '0));
    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond && !tick) |=> $stable(cnt));
    // R2
    bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAX_COUNT));
endmodule

// File: rtl/cog_drive.sv
// Output stage: maps overcharge status to the charge-control pin level and
// enable according to build-time polarity and form.
// Assumes: purely combinational; open-drain inactive level is high impedance.
module cog_drive #(
    parameter bit ACTIVE_HIGH = 1'b1,
    parameter bit OPEN_DRAIN  = 1'b0
) (
    input  logic active,
    output logic pin_out,
    output logic pin_oe
);
    // Level follows polarity in both forms.
    always_comb pin_out = ACTIVE_HIGH ? active : !active;

    generate
        if (OPEN_DRAIN) begin : g_od
            // Drive only when active; release the pin otherwise.
            always_comb pin_oe = active;
        end else begin : g_pp
            // Push-pull always drives.
            always_comb pin_oe = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/cell_ovc_guard.sv
// Cell overcharge delay controller (top).
// Qualifies per-cell overcharge and release flags with separate tick-counted
// delays, keeps a latched test mode that shortens detection, and drives the
// charge-control output.
// Assumes: all flag inputs already synchronized to clk; tick is one clk wide.
module cell_ovc_guard #(
    parameter int NUM_CELLS        = 3,
    parameter int DET_BASE_TICKS   = 2000,
    parameter int DELAY_CODE       = 0,
    parameter int TEST_DET_TICKS   = 32,
    parameter int REL_TICKS        = 2,
    parameter int TEST_ENTRY_TICKS = 20,
    parameter bit ACTIVE_HIGH      = 1'b1,
    parameter bit OPEN_DRAIN       = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 two_cell,
    input  logic [NUM_CELLS-1:0] ovc_flag,
    input  logic [NUM_CELLS-1:0] rel_flag,
    input  logic                 test_req,
    output logic                 chg_out,
    output logic                 chg_oe
);
    import cog_pkg::*;

    localparam int DET_TICKS = DET_BASE_TICKS << DELAY_CODE;
    localparam int MAX_LIM   = imax(imax(DET_TICKS, TEST_DET_TICKS),
                                    imax(REL_TICKS, TEST_ENTRY_TICKS));
    localparam int CW        = $clog2(MAX_LIM + 1);

    guard_state_t          state;
    logic                  test_mode;
    logic [NUM_CELLS-1:0]  ovc_eff, rel_eff;
    logic                  det_cond, rel_cond, ent_cond;
    logic                  det_fire, rel_fire, ent_fire;
    logic [CW-1:0]         det_limit;
    logic                  in_ovc;

    // Per-cell masking of the top cell in the reduced pack.
    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
        if (i == NUM_CELLS - 1) begin : g_top
            // Top cell: ignored when the pack is one cell short.
            always_comb begin
                ovc_eff[i] = ovc_flag[i] && !two_cell;
                rel_eff[i] = rel_flag[i] || two_cell;
            end
        end else begin : g_low
            // Lower cells always take part.
            always_comb begin
                ovc_eff[i] = ovc_flag[i];
                rel_eff[i] = rel_flag[i];
            end
        end
    end

    // Conditions and the active detection limit.
    always_comb begin
        in_ovc    = (state == ST_OVC);
        det_cond  = !in_ovc && (|ovc_eff);
        rel_cond  = in_ovc && (&rel_eff);
        ent_cond  = test_req && !test_mode;
        det_limit = test_mode ? CW'(TEST_DET_TICKS) : CW'(DET_TICKS);
    end

    cog_qual_timer #(.MAX_COUNT(MAX_LIM)) u_det (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cond(det_cond),
        .limit(det_limit), .fire(det_fire)
    );

    cog_qual_timer #(.MAX_COUNT(MAX_LIM)) u_rel (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cond(rel_cond),
        .limit(CW'(REL_TICKS)), .fire(rel_fire)
    );

    cog_qual_timer #(.MAX_COUNT(MAX_LIM)) u_ent (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cond(ent_cond),
        .limit(CW'(TEST_ENTRY_TICKS)), .fire(ent_fire)
    );

    // Status register: normal <-> overcharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_NORMAL;
        end else if (det_fire) begin
            state <= ST_OVC;
        end else if (rel_fire) begin
            state <= ST_NORMAL;
        end
    end

    // Test-mode latch: set by held entry, cleared on reaching overcharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_mode <= 1'b0;
        end else if (det_fire) begin
            test_mode <= 1'b0;
        end else if (ent_fire) begin
            test_mode <= 1'b1;
        end
    end

    cog_drive #(.ACTIVE_HIGH(ACTIVE_HIGH), .OPEN_DRAIN(OPEN_DRAIN)) u_drive (
        .active(in_ovc), .pin_out(chg_out), .pin_oe(chg_oe)
    );

    // R2
    det_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ovc) |-> $past(|ovc_eff));
    // R4
    rel_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ovc) |-> $past(&rel_eff));
    // R7
    test_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ovc) |-> !test_mode);
    // R5
    test_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_mode) |-> $past(test_req));
    // R10
    top_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(in_ovc) && $past(two_cell)) |-> $past(|ovc_flag[NUM_CELLS-2:0]));
    // R8
    polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ovc && chg_oe) |-> (chg_out == ACTIVE_HIGH));
    // R9
    form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ovc && OPEN_DRAIN) |-> !chg_oe);
endmodule

// File: tb/cell_ovc_guard_bench.sv
`timescale 1ns/1ps
module cell_ovc_guard_bench;
    localparam int NC     = 3;
    localparam int BASE   = 8;
    localparam int CODE   = 1;
    localparam int DET    = BASE << CODE;   // 16
    localparam int TDET   = 4;
    localparam int REL    = 3;
    localparam int ENTRY  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic two_cell = 1'b0;
    logic [NC-1:0] ovc_flag = '0;
    logic [NC-1:0] rel_flag = '0;
    logic test_req = 1'b0;
    logic pp_out, pp_oe, od_out, od_oe;
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    always #2.5 clk = ~clk;

    cell_ovc_guard #(.NUM_CELLS(NC), .DET_BASE_TICKS(BASE), .DELAY_CODE(CODE),
        .TEST_DET_TICKS(TDET), .REL_TICKS(REL), .TEST_ENTRY_TICKS(ENTRY),
        .ACTIVE_HIGH(1'b1), .OPEN_DRAIN(1'b0)) u_cell_ovc_guard (
        .clk(clk), .rst_n(rst_n), .tick(tick), .two_cell(two_cell),
        .ovc_flag(ovc_flag), .rel_flag(rel_flag), .test_req(test_req),
        .chg_out(pp_out), .chg_oe(pp_oe));

    cell_ovc_guard #(.NUM_CELLS(NC), .DET_BASE_TICKS(BASE), .DELAY_CODE(CODE),
        .TEST_DET_TICKS(TDET), .REL_TICKS(REL), .TEST_ENTRY_TICKS(ENTRY),
        .ACTIVE_HIGH(1'b0), .OPEN_DRAIN(1'b1)) u_cell_ovc_guard_od (
        .clk(clk), .rst_n(rst_n), .tick(tick), .two_cell(two_cell),
        .ovc_flag(ovc_flag), .rel_flag(rel_flag), .test_req(test_req),
        .chg_out(od_out), .chg_oe(od_oe));

    // Advance n rising edges, then settle at the falling edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Compare both builds against the expected status.
    task automatic expect_st(input bit ovc, input string tag);
        n_tests++;
        if (pp_out !== ovc || pp_oe !== 1'b1) begin
            n_fail++;
            $display("FAIL %s R8 push-pull: out=%b oe=%b expected out=%b oe=1",
                     tag, pp_out, pp_oe, ovc);
        end
        n_tests++;
        if (od_oe !== ovc || (ovc && od_out !== 1'b0)) begin
            n_fail++;
            $display("FAIL %s R9 open-drain: out=%b oe=%b expected oe=%b out=0",
                     tag, od_out, od_oe, ovc);
        end
    endtask

    // Leave overcharge with all release flags held REL ticks.
    task automatic release_all(input string tag);
        ovc_flag = '0;
        rel_flag = '1;
        step(REL - 1);
        expect_st(1'b1, tag);
        step(1);
        expect_st(1'b0, tag);
    endtask

    initial begin
        @(negedge clk);
        step(3);
        expect_st(1'b0, "R1 reset");
        rst_n = 1'b1;
        step(1);
        expect_st(1'b0, "R1 after reset");

        // R11: no tick, no progress
        tick = 1'b0;
        ovc_flag = 3'b001;
        step(40);
        expect_st(1'b0, "R11 no tick");
        tick = 1'b1;
        step(DET - 1);
        expect_st(1'b0, "R2 one before delay");
        step(1);
        expect_st(1'b1, "R2 delay reached");
        release_all("R4 release");

        // R3: bursts of every length below the delay
        for (int len = 1; len < DET; len++) begin
            ovc_flag = NC'(1 << (len % NC));
            step(len);
            ovc_flag = '0;
            step(1);
            expect_st(1'b0, "R3 burst");
        end

        // R2 per cell, R4 each missing release flag
        for (int c = 0; c < NC; c++) begin
            ovc_flag = NC'(1 << c);
            rel_flag = '0;
            step(DET - 1);
            expect_st(1'b0, "R2 cell pre");
            step(1);
            expect_st(1'b1, "R2 cell hit");
            ovc_flag = '0;
            rel_flag = ~NC'(1 << c);
            step(10);
            expect_st(1'b1, "R4 one flag missing");
            rel_flag = '1;
            step(REL - 1);
            rel_flag = '0;
            step(1);
            expect_st(1'b1, "R4 release glitch");
            release_all("R4 full release");
        end

        // R10: top cell ignored in reduced pack
        two_cell = 1'b1;
        rel_flag = '0;
        ovc_flag = 3'b100;
        step(DET + 10);
        expect_st(1'b0, "R10 top ovc ignored");
        ovc_flag = 3'b001;
        step(DET);
        expect_st(1'b1, "R10 low cell detects");
        ovc_flag = '0;
        rel_flag = 3'b011;
        step(REL);
        expect_st(1'b0, "R10 top rel ignored");
        two_cell = 1'b0;
        rel_flag = '0;

        // R5: short hold latches nothing
        test_req = 1'b1;
        step(ENTRY - 1);
        test_req = 1'b0;
        step(1);
        ovc_flag = 3'b010;
        step(TDET);
        expect_st(1'b0, "R5 short entry ignored");
        step(DET - TDET - 1);
        expect_st(1'b0, "R5 normal delay pre");
        step(1);
        expect_st(1'b1, "R5 normal delay hit");
        release_all("R4 release");

        // R5/R6: latched test mode survives request drop, shortens delay
        test_req = 1'b1;
        step(ENTRY);
        test_req = 1'b0;
        step(20);
        ovc_flag = 3'b100;
        step(TDET - 1);
        expect_st(1'b0, "R6 test delay pre");
        step(1);
        expect_st(1'b1, "R6 test delay hit");
        release_all("R4 release");

        // R7: latch cleared by overcharge, normal delay again
        ovc_flag = 3'b001;
        step(DET - 1);
        expect_st(1'b0, "R7 normal delay pre");
        step(1);
        expect_st(1'b1, "R7 normal delay hit");
        release_all("R4 release");

        // R1: reset from overcharge
        ovc_flag = 3'b001;
        step(DET);
        expect_st(1'b1, "R1 pre reset");
        rst_n = 1'b0;
        step(1);
        expect_st(1'b0, "R1 reset clears");
        rst_n = 1'b1;
        ovc_flag = '0;
        step(2);
        expect_st(1'b0, "R1 stays normal");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5ns * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule